// File: doc/BRIEF.md
# JTAG Command Bridge to a Register Port

This block lives behind one data register of a JTAG test access port and converts each 32-bit word shifted into it into at most one access on a plain parallel register port of a monitoring peripheral. The port side runs on its own clock. A toggle crosses the update event from the test clock into the port clock through a two-flop synchroniser. While an access waits for `reg_ready`, the block is busy and keeps any later command pending.

Reads are not returned in the scan that issues them. The port result is stored, and the next capture loads it into the shift register, together with the address it came from. A host therefore follows every read with a second scan, normally a no-op, to collect the data. Writes to the four lowest addresses do not reach the port. Address 3 raises a converter-reset strobe and address 0 raises a lock strobe, and both present the written data on `sf_data`. Addresses 1 and 2 do nothing when written.

Top module: `jtag_reg_bridge`

## Requirements
- R1: The data register responds to capture, shift and update only while `ir_code` equals 0x37. With any other code, scans start no access and leave the stored read result unchanged.
- R2: During shift, each rising `tck` edge moves `tdi` into bit 31 and the word toward bit 0. `tdo` always shows bit 0, so a 32-bit word leaves least significant bit first.
- R3: Capture loads {6'b0, address[9:0], data[15:0]} of the most recently completed read. If no read has completed since reset, capture loads zero.
- R4: An update decodes the shifted word as opcode = bits 29:26, address = bits 25:16 and data = bits 15:0. Bits 31:30 have no effect.
- R5: Opcode 1 with an address in 0x00..0x5F makes one port read (`reg_en`=1, `reg_we`=0). The value on `reg_rdata` in the cycle `reg_ready` is high becomes the stored read result.
- R6: Opcode 2 with an address in 0x04..0x5F makes one port write with `reg_addr` and `reg_wdata` taken from the command.
- R7: Opcode 0 and the reserved opcodes 3..15 make no port access and leave the stored read result unchanged.
- R8: A write to address 0x03 makes no port access. It gives a one-cycle `sf_reset` pulse, and `sf_data` takes the written data.
- R9: A write to address 0x00 makes no port access. It gives a one-cycle `sf_lock` pulse, and `sf_data` takes the written data.
- R10: Writes to addresses 0x01 and 0x02 make no port access, give no pulse and leave `sf_data` unchanged.
- R11: A write to an address above 0x5F is ignored. A read of such an address makes no port access, and its stored result has data 0x0000 and carries the requested address.
- R12: `reg_en`, `reg_we`, `reg_addr` and `reg_wdata` hold steady until `reg_ready` is seen. Only one access is outstanding at a time. An update that arrives while an access is in progress is carried out after that access completes, in arrival order.
- R13: Reads of addresses 0x00..0x03 go to the port like any other in-range read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-port clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| tck | input | 1 | Test clock |
| ir_code | input | 6 | Current instruction register value |
| capture_dr | input | 1 | Capture strobe, sampled on rising `tck` |
| shift_dr | input | 1 | Shift strobe, sampled on rising `tck` |
| update_dr | input | 1 | Update strobe, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, bit 0 of the shift register |
| reg_en | output | 1 | Access in progress on the register port |
| reg_we | output | 1 | Access is a write |
| reg_addr | output | 7 | Register address |
| reg_wdata | output | 16 | Write data |
| reg_rdata | input | 16 | Read data, valid while `reg_ready` is high |
| reg_ready | input | 1 | Access complete |
| sf_lock | output | 1 | One-cycle lock strobe |
| sf_reset | output | 1 | One-cycle converter-reset strobe |
| sf_data | output | 16 | Data of the last special write |

## Verification
A corrupted stored read result, or a stored result taken from the wrong access, appears in the very next scan after the read, as a wrong address or data field in the shifted-out word. This is why the bench chains reads over the whole address range and compares every returned word. A wrong decode shows up within the 10-cycle idle gap after the update: an unexpected or missing port access, or an extra or missing strobe pulse. A stuck busy state or a lost pending command shows up as a missing or out-of-order port write after a slow access.

// File: rtl/jrb_pkg.sv
package jrb_pkg;
  localparam int CMD_W    = 32;
  localparam int DATA_W   = 16;
  localparam int AFLD_W   = 10;
  localparam int OP_W     = 4;
  localparam int CW       = OP_W + AFLD_W + DATA_W;   // decoded part of the word
  localparam int PAD_W    = CMD_W - AFLD_W - DATA_W;  // zero bits above the address on capture

  localparam logic [OP_W-1:0] OP_NOP = 4'd0;
  localparam logic [OP_W-1:0] OP_RD  = 4'd1;
  localparam logic [OP_W-1:0] OP_WR  = 4'd2;

  typedef enum logic {ST_IDLE, ST_ACCESS} pst_e;
endpackage

// File: rtl/jrb_rst_sync.sv
module jrb_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] ff_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) ff_q <= '0;
    else         ff_q <= {ff_q[0], 1'b1};
  end

  assign srst_n = ff_q[1];
endmodule

// File: rtl/jrb_tap_shift.sv
module jrb_tap_shift
  import jrb_pkg::*;
#(
  parameter int              IR_W     = 6,
  parameter logic [IR_W-1:0] SEL_CODE = 6'h37
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic [IR_W-1:0]   ir_code,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  output logic              tdo,
  input  logic              rd_vld,
  input  logic [AFLD_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic [CW-1:0]     cmd_word,
  output logic              req_tgl
);
  logic             sel, upd;
  logic [CMD_W-1:0] sr_q, sr_nxt;
  logic [CW-1:0]    cmd_q, cmd_nxt;
  logic             tgl_q, tgl_nxt;

  assign sel = (ir_code == SEL_CODE);
  assign upd = sel && update_dr;

  always_comb begin
    sr_nxt = sr_q;
    if (sel && capture_dr) begin
      sr_nxt = rd_vld ? {{PAD_W{1'b0}}, rd_addr, rd_data} : '0;
    end else if (sel && shift_dr) begin
      sr_nxt = {tdi, sr_q[CMD_W-1:1]};
    end
  end

  always_comb begin
    cmd_nxt = cmd_q;
    tgl_nxt = tgl_q;
    if (upd) begin
      cmd_nxt = sr_q[CW-1:0];
      tgl_nxt = ~tgl_q;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cmd_q <= '0;
      tgl_q <= 1'b0;
    end else begin
      sr_q  <= sr_nxt;
      cmd_q <= cmd_nxt;
      tgl_q <= tgl_nxt;
    end
  end

  assign tdo      = sr_q[0];
  assign cmd_word = cmd_q;
  assign req_tgl  = tgl_q;
endmodule

// File: rtl/jrb_port_ctl.sv
module jrb_port_ctl
  import jrb_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int MAX_ADDR  = 'h5F,
  parameter int SPC_LOCK  = 0,
  parameter int SPC_RESET = 3,
  parameter int SPC_LAST  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     cmd_word,
  input  logic              req_tgl,
  output logic              reg_en,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic              reg_ready,
  output logic              rd_vld,
  output logic [AFLD_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              sf_lock,
  output logic              sf_reset,
  output logic [DATA_W-1:0] sf_data
);
  logic [OP_W-1:0]   c_op;
  logic [AFLD_W-1:0] c_addr;
  logic [DATA_W-1:0] c_data;
  logic              in_rng, is_spc, take, req_edge;

  logic [2:0]        sync_q;
  pst_e              st_q, st_n;
  logic              pend_q, pend_n;
  logic              we_q, we_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [DATA_W-1:0] wd_q, wd_n;
  logic              rdv_q, rdv_n;
  logic [AFLD_W-1:0] rda_q, rda_n;
  logic [DATA_W-1:0] rdd_q, rdd_n;
  logic              lock_q, lock_n, rst_q, rst_n_sf;
  logic [DATA_W-1:0] sfd_q, sfd_n;

  assign c_op     = cmd_word[CW-1 -: OP_W];
  assign c_addr   = cmd_word[DATA_W +: AFLD_W];
  assign c_data   = cmd_word[DATA_W-1:0];
  assign in_rng   = (c_addr <= AFLD_W'(MAX_ADDR));
  assign is_spc   = (c_addr <= AFLD_W'(SPC_LAST));
  assign req_edge = sync_q[2] ^ sync_q[1];
  assign take     = (st_q == ST_IDLE) && pend_q;

  always_comb begin
    st_n     = st_q;
    pend_n   = req_edge | (pend_q & ~take);
    we_n     = we_q;
    addr_n   = addr_q;
    wd_n     = wd_q;
    rdv_n    = rdv_q;
    rda_n    = rda_q;
    rdd_n    = rdd_q;
    lock_n   = 1'b0;
    rst_n_sf = 1'b0;
    sfd_n    = sfd_q;
    if (take) begin
      if (c_op == OP_RD) begin
        if (in_rng) begin
          st_n   = ST_ACCESS;
          we_n   = 1'b0;
          addr_n = c_addr[ADDR_W-1:0];
        end else begin
          rdv_n = 1'b1;
          rda_n = c_addr;
          rdd_n = '0;
        end
      end else if (c_op == OP_WR) begin
        if (in_rng && !is_spc) begin
          st_n   = ST_ACCESS;
          we_n   = 1'b1;
          addr_n = c_addr[ADDR_W-1:0];
          wd_n   = c_data;
        end else if (c_addr == AFLD_W'(SPC_LOCK)) begin
          lock_n = 1'b1;
          sfd_n  = c_data;
        end else if (c_addr == AFLD_W'(SPC_RESET)) begin
          rst_n_sf = 1'b1;
          sfd_n    = c_data;
        end
      end
    end else if ((st_q == ST_ACCESS) && reg_ready) begin
      st_n = ST_IDLE;
      if (!we_q) begin
        rdv_n = 1'b1;
        rda_n = AFLD_W'(addr_q);
        rdd_n = reg_rdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
      we_q   <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
      rdv_q  <= 1'b0;
      rda_q  <= '0;
      rdd_q  <= '0;
      lock_q <= 1'b0;
      rst_q  <= 1'b0;
      sfd_q  <= '0;
    end else begin
      sync_q <= {sync_q[1:0], req_tgl};
      st_q   <= st_n;
      pend_q <= pend_n;
      we_q   <= we_n;
      addr_q <= addr_n;
      wd_q   <= wd_n;
      rdv_q  <= rdv_n;
      rda_q  <= rda_n;
      rdd_q  <= rdd_n;
      lock_q <= lock_n;
      rst_q  <= rst_n_sf;
      sfd_q  <= sfd_n;
    end
  end

  assign reg_en    = (st_q == ST_ACCESS);
  assign reg_we    = we_q;
  assign reg_addr  = addr_q;
  assign reg_wdata = wd_q;
  assign rd_vld    = rdv_q;
  assign rd_addr   = rda_q;
  assign rd_data   = rdd_q;
  assign sf_lock   = lock_q;
  assign sf_reset  = rst_q;
  assign sf_data   = sfd_q;
endmodule

// File: rtl/jtag_reg_bridge.sv
module jtag_reg_bridge
  import jrb_pkg::*;
#(
  parameter int              IR_W     = 6,
  parameter logic [IR_W-1:0] SEL_CODE = 6'h37,
  parameter int              ADDR_W   = 7,
  parameter int              MAX_ADDR = 'h5F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tck,
  input  logic [IR_W-1:0]   ir_code,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  output logic              tdo,
  output logic              reg_en,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic              reg_ready,
  output logic              sf_lock,
  output logic              sf_reset,
  output logic [DATA_W-1:0] sf_data
);
  logic              tck_rst_n, clk_rst_n;
  logic [CW-1:0]     cmd_word;
  logic              req_tgl, rd_vld;
  logic [AFLD_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;

  jrb_rst_sync u_rst_tck (.clk(tck), .arst_n(rst_n), .srst_n(tck_rst_n));
  jrb_rst_sync u_rst_clk (.clk(clk), .arst_n(rst_n), .srst_n(clk_rst_n));

  jrb_tap_shift #(.IR_W(IR_W), .SEL_CODE(SEL_CODE)) u_shift (
    .tck(tck), .rst_n(tck_rst_n), .ir_code(ir_code),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdi(tdi), .tdo(tdo),
    .rd_vld(rd_vld), .rd_addr(rd_addr), .rd_data(rd_data),
    .cmd_word(cmd_word), .req_tgl(req_tgl)
  );

  jrb_port_ctl #(.ADDR_W(ADDR_W), .MAX_ADDR(MAX_ADDR)) u_port (
    .clk(clk), .rst_n(clk_rst_n), .cmd_word(cmd_word), .req_tgl(req_tgl),
    .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_ready(reg_ready),
    .rd_vld(rd_vld), .rd_addr(rd_addr), .rd_data(rd_data),
    .sf_lock(sf_lock), .sf_reset(sf_reset), .sf_data(sf_data)
  );
endmodule

// File: rtl/jrb_checker.sv
module jrb_checker #(
  parameter int ADDR_W   = 7,
  parameter int MAX_ADDR = 'h5F
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_en,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [15:0]       reg_wdata,
  input logic              reg_ready,
  input logic              sf_lock,
  input logic              sf_reset
);
  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && !reg_ready) |=> (reg_en && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata)));

  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && reg_ready) |=> !reg_en);

  assert_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_en |-> (int'(reg_addr) <= MAX_ADDR));

  assert_nospc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && reg_we) |-> (int'(reg_addr) > 3));

  assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sf_reset |=> !sf_reset);

  assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sf_lock |=> !sf_lock);

  assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_lock || sf_reset) |-> (!reg_en && $onehot0({sf_lock, sf_reset})));
endmodule

bind jtag_reg_bridge jrb_checker #(.ADDR_W(ADDR_W), .MAX_ADDR(MAX_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_ready(reg_ready), .sf_lock(sf_lock), .sf_reset(sf_reset)
);

// File: tb/tb_jtag_reg_bridge.sv
module tb_jtag_reg_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tck = 1'b0;
  logic [5:0]  ir_code = 6'h37;
  logic        capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
  logic        tdo;
  logic        reg_en, reg_we;
  logic [6:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata = '0;
  logic        reg_ready = 1'b0;
  logic        sf_lock, sf_reset;
  logic [15:0] sf_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] mem [0:127];
  logic [6:0]  wlog [0:7];
  int lat = 0, wr_cnt = 0, rd_cnt = 0, lock_cnt = 0, rst_cnt = 0, wlog_n = 0, cnt = 0;

  jtag_reg_bridge dut (
    .clk(clk), .rst_n(rst_n), .tck(tck), .ir_code(ir_code),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdi(tdi), .tdo(tdo), .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ready(reg_ready),
    .sf_lock(sf_lock), .sf_reset(sf_reset), .sf_data(sf_data)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [3:0] op, input logic [9:0] a, input logic [15:0] d);
    return {2'b00, op, a, d};
  endfunction

  function automatic logic [15:0] wval(input int a);
    return 16'(a * 257) ^ 16'h5A3C;
  endfunction

  task automatic tpulse();
    #20 tck = 1'b1;
    #20 tck = 1'b0;
  endtask

  task automatic scan(input logic [31:0] din, output logic [31:0] dout);
    capture_dr = 1'b1; tpulse(); capture_dr = 1'b0; shift_dr = 1'b1;
    for (int i = 0; i < 32; i++) begin
      tdi = din[i];
      dout[i] = tdo;
      tpulse();
    end
    shift_dr = 1'b0; update_dr = 1'b1; tpulse(); update_dr = 1'b0;
    repeat (10) tpulse();
  endtask

  // register-port responder
  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 16'hC000 | 16'(i);
    forever begin
      @(negedge clk);
      if (reg_ready) reg_ready = 1'b0;
      else if (reg_en) begin
        if (cnt >= lat) begin
          reg_ready = 1'b1;
          cnt = 0;
          if (reg_we) begin
            mem[reg_addr] = reg_wdata;
            wr_cnt++;
            wlog[wlog_n % 8] = reg_addr;
            wlog_n++;
          end else begin
            reg_rdata = mem[reg_addr];
            rd_cnt++;
          end
        end else cnt++;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (sf_lock)  lock_cnt++;
      if (sf_reset) rst_cnt++;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic        pv;
    logic [9:0]  pa;
    logic [15:0] pd;
    int w0, r0, l0, s0;
    pv = 0; pa = '0; pd = '0;

    repeat (2) tpulse();
    chk("R3 reset en", {31'b0, reg_en}, 0);
    chk("R8 R9 reset pulses", {30'b0, sf_lock, sf_reset}, 0);
    chk("R2 reset tdo", {31'b0, tdo}, 0);
    #30 rst_n = 1'b1;
    repeat (4) tpulse();

    scan(mk(4'd0, 10'h0, 16'h0), d);
    chk("R3 no read yet", d, 0);

    // write sweep
    for (int a = 4; a <= 'h5F; a++) begin
      lat = a % 4;
      scan(mk(4'd2, 10'(a), wval(a)), d);
    end
    chk("R6 write count", wr_cnt, 92);
    for (int a = 4; a <= 'h5F; a++) chk("R6 stored", {16'b0, mem[a]}, {16'b0, wval(a)});

    // chained reads over the whole range
    for (int a = 0; a <= 'h5F; a++) begin
      lat = (a * 3) % 4;
      scan(mk(4'd1, 10'(a), 16'h0), d);
      chk("R2 R3 R5 R13 read chain", d, pv ? {6'b0, pa, pd} : 32'h0);
      pv = 1; pa = 10'(a);
      pd = (a < 4) ? (16'hC000 | 16'(a)) : wval(a);
    end
    scan(mk(4'd0, 10'h0, 16'h0), d);
    chk("R5 last read", d, {6'b0, pa, pd});
    chk("R5 R13 read count", rd_cnt, 96);

    // no-ops and reserved opcodes
    w0 = wr_cnt; r0 = rd_cnt;
    for (int op = 3; op <= 15; op++) scan(mk(4'(op), 10'h010, 16'hFFFF), d);
    scan(mk(4'd0, 10'h011, 16'hFFFF), d);
    chk("R7 no write", wr_cnt, w0);
    chk("R7 no read", rd_cnt, r0);
    chk("R7 mem kept", {16'b0, mem['h10]}, {16'b0, wval('h10)});
    chk("R7 result kept", d, {6'b0, pa, pd});

    // high bits ignored
    scan({2'b11, 4'd2, 10'h020, 16'h1234}, d);
    chk("R4 write with top bits", {16'b0, mem['h20]}, 32'h1234);
    scan({2'b10, 4'd1, 10'h020, 16'h0}, d);
    scan(mk(4'd0, 10'h0, 16'h0), d);
    pa = 10'h020; pd = 16'h1234;
    chk("R4 read with top bits", d, {6'b0, pa, pd});

    // special addresses
    w0 = wr_cnt; l0 = lock_cnt; s0 = rst_cnt;
    scan(mk(4'd2, 10'h003, 16'hBEEF), d);
    chk("R8 reset pulse", rst_cnt, s0 + 1);
    chk("R8 data", {16'b0, sf_data}, 32'hBEEF);
    chk("R8 no port write", wr_cnt, w0);
    scan(mk(4'd2, 10'h000, 16'h00A5), d);
    chk("R9 lock pulse", lock_cnt, l0 + 1);
    chk("R9 data", {16'b0, sf_data}, 32'h00A5);
    chk("R9 no port write", wr_cnt, w0);
    scan(mk(4'd2, 10'h001, 16'h7777), d);
    scan(mk(4'd2, 10'h002, 16'h8888), d);
    chk("R10 no write", wr_cnt, w0);
    chk("R10 no pulse", lock_cnt + rst_cnt, l0 + s0 + 2);
    chk("R10 data kept", {16'b0, sf_data}, 32'h00A5);
    chk("R10 R13 mem kept", {16'b0, mem[1]}, 32'hC001);

    // out of range
    r0 = rd_cnt;
    scan(mk(4'd2, 10'h060, 16'h4444), d);
    scan(mk(4'd2, 10'h3FF, 16'h5555), d);
    chk("R11 write ignored", wr_cnt, w0);
    chk("R11 low alias kept", {16'b0, mem['h60 & 'h7F]}, 32'hC060);
    scan(mk(4'd1, 10'h060, 16'h0), d);
    scan(mk(4'd1, 10'h3FF, 16'h0), d);
    chk("R11 read 0x60", d, {6'b0, 10'h060, 16'h0});
    scan(mk(4'd0, 10'h0, 16'h0), d);
    chk("R11 read 0x3FF", d, {6'b0, 10'h3FF, 16'h0});
    chk("R11 no port read", rd_cnt, r0);

    // instruction not selected
    ir_code = 6'h02;
    scan(mk(4'd2, 10'h030, 16'hAAAA), d);
    scan(mk(4'd1, 10'h031, 16'h0), d);
    ir_code = 6'h37;
    scan(mk(4'd0, 10'h0, 16'h0), d);
    chk("R1 no write", wr_cnt, w0);
    chk("R1 no read", rd_cnt, r0);
    chk("R1 mem kept", {16'b0, mem['h30]}, {16'b0, wval('h30)});
    chk("R1 result kept", d, {6'b0, 10'h3FF, 16'h0});

    // slow port, commands queue behind busy
    lat = 500; wlog_n = 0;
    scan(mk(4'd2, 10'h041, 16'h1111), d);
    scan(mk(4'd2, 10'h042, 16'h2222), d);
    scan(mk(4'd2, 10'h040, 16'h3333), d);
    repeat (2000) @(posedge clk);
    #1;
    chk("R12 write count", wlog_n, 3);
    chk("R12 order 0", {25'b0, wlog[0]}, 32'h41);
    chk("R12 order 1", {25'b0, wlog[1]}, 32'h42);
    chk("R12 order 2", {25'b0, wlog[2]}, 32'h40);
    chk("R12 data", {mem['h41], mem['h40]}, 32'h1111_3333);
    chk("R12 data 2", {16'b0, mem['h42]}, 32'h2222);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule